// File: doc/BRIEF.md
# Eight-bit timer/counter with compare and PWM waveform

This block is an 8-bit timer/counter with a single compare channel and one waveform output. It advances only on cycles where the prescaled tick input is high and a non-zero clock select is programmed. A 2-bit mode field picks one of four counting schemes: free-running (normal), clear-on-compare, fast PWM (single slope) or phase-correct PWM (up then down). A 2-bit output-mode field decides what the waveform output does on a compare match, and whether it replaces the plain port value on the pin at all.

Software reaches the block through a byte-wide register port with four addresses. Address 0 is control: bits [1:0] mode (0 normal, 1 clear-on-compare, 2 fast PWM, 3 phase-correct), bits [3:2] output mode, bits [5:4] clock select, bit 7 a write-only force-compare strobe. Reads of address 0 return {2'b00, clock select, output mode, mode}. Address 1 is the count. Address 2 is the compare value, and reads return the value last written. Address 3 holds the flags: bit 0 overflow, bit 1 compare. The overflow and compare flags also appear on dedicated outputs. Writing a one to a flag bit clears that flag.

Read data is combinational from the current state. Writes and tick events take effect at the rising clock edge. In every mode the events of a tick are decided from the count, direction and active compare value held before that edge.

Top module: `tmr8_pwm`

## Requirements
- R1: After reset the count, the compare value, the control fields and both flags read as zero, and pin_o follows port_i.
- R2: With clock select 0, tick_i has no effect and the count holds its value.
- R3: In normal mode each tick adds one to the count. A tick at count 0xFF wraps the count to 0x00 and sets the overflow flag.
- R4: In clear-on-compare mode, a tick at which the count equals the active compare value loads 0 into the count and sets the compare flag. If the compare value is written below the count, no match occurs until the count has passed 0xFF and wrapped through 0x00. A tick at 0xFF sets the overflow flag.
- R5: In fast PWM mode the count runs 0x00 to 0xFF and wraps, and the tick at 0xFF sets the overflow flag. With output mode 2, the tick at 0xFF drives the output high; otherwise a match drives it low. Output mode 3 drives the opposite levels.
- R6: In phase-correct mode the count rises to 0xFF and then falls to 0x00. The tick at 0x00 sets the overflow flag. With output mode 2, a match while rising drives the output low and a match while falling drives it high. Output mode 3 drives the opposite levels.
- R7: In both PWM modes a compare write goes to a buffer. The buffer becomes the active compare value on the tick at 0xFF. In normal and clear-on-compare modes a compare write becomes active at once.
- R8: In every mode, a tick at which the count equals the active compare value sets the compare flag.
- R9: Writing address 3 clears each flag whose data bit is 1 and leaves the other flag unchanged. A flag event in the same cycle wins over the clear.
- R10: With output mode 0, pin_o equals port_i. With any other output mode, pin_o carries the waveform output.
- R11: In normal and clear-on-compare modes a match changes the waveform output according to the output mode: 1 toggles it, 2 clears it, 3 sets it. In the PWM modes, output mode 1 leaves the waveform output unchanged.
- R12: A control write with bit 7 set applies the R11 action of the written output mode at once, but only when the written mode is normal or clear-on-compare. It sets no flag and leaves the count unchanged. In the PWM modes the output does not change. Bit 7 always reads back as 0.
- R13: A count write loads the written value. In that cycle the tick is suppressed: no count step, no flag and no output change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Prescaled count enable |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for addr_i |
| port_i | input | 1 | Plain port value used when the waveform is disconnected |
| pin_o | output | 1 | Pin value: waveform or port_i |
| ovf_o | output | 1 | Overflow flag |
| cmp_o | output | 1 | Compare flag |

## Verification
The count, the flags, the waveform and the active compare value all change at the rising edge that samples a tick or a write. They therefore show on rdata_o, pin_o, ovf_o and cmp_o from the following falling edge. The only exception is pin_o under output mode 0, which follows port_i in the same cycle. The bench drives every input just after a falling edge and compares the outputs against a reference state that is one edge old. Only after that comparison does it advance the reference by the same tick and write. Directed sequences count the exact number of ticks to the compare point, the 0xFF wrap and the buffer load, and then read the outputs at the falling edge that follows.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  typedef enum logic [1:0] {
    MODE_NORM  = 2'd0,
    MODE_CTC   = 2'd1,
    MODE_FAST  = 2'd2,
    MODE_PHASE = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_CNT  = 2'd1,
    ADDR_CMP  = 2'd2,
    ADDR_FLAG = 2'd3
  } addr_e;

  typedef struct packed {
    logic [1:0] cs;
    logic [1:0] om;
    mode_e      mode;
  } ctrl_t;

  localparam int CTRL_W    = $bits(ctrl_t);
  localparam int FORCE_BIT = 7;

  // non-PWM compare action
  function automatic logic cmp_action(input logic [1:0] om, input logic cur);
    case (om)
      2'd1:    cmp_action = ~cur;
      2'd2:    cmp_action = 1'b0;
      2'd3:    cmp_action = 1'b1;
      default: cmp_action = cur;
    endcase
  endfunction

  // PWM drive: om 2 gives lvl, om 3 gives ~lvl, else hold
  function automatic logic pwm_drive(input logic [1:0] om, input logic lvl, input logic cur);
    case (om)
      2'd2:    pwm_drive = lvl;
      2'd3:    pwm_drive = ~lvl;
      default: pwm_drive = cur;
    endcase
  endfunction
endpackage

// File: rtl/tmr8_regs.sv
module tmr8_regs
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [1:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] cnt_i,
  input  logic         ovf_ev_i,
  input  logic         cmp_ev_i,
  input  logic         upd_i,
  output ctrl_t        ctrl_o,
  output logic [W-1:0] act_o,
  output logic         ovf_o,
  output logic         cmp_o,
  output logic         cnt_wr_o,
  output logic         force_o,
  output logic [1:0]   force_om_o,
  output logic [W-1:0] rdata_o
);
  ctrl_t        ctrl_q;
  logic [W-1:0] buf_q, act_q;
  logic         ovf_q, cmp_q;
  logic         wr_ctrl, wr_cmp, wr_flag;
  logic         pwm;
  logic         unused_wbits;

  assign wr_ctrl  = wr_en_i && (addr_i == ADDR_CTRL);
  assign cnt_wr_o = wr_en_i && (addr_i == ADDR_CNT);
  assign wr_cmp   = wr_en_i && (addr_i == ADDR_CMP);
  assign wr_flag  = wr_en_i && (addr_i == ADDR_FLAG);
  assign pwm      = ctrl_q.mode[1];

  // force honoured only when the written mode is non-PWM
  assign force_o    = wr_ctrl && wdata_i[FORCE_BIT] && !wdata_i[1];
  assign force_om_o = wdata_i[3:2];
  assign unused_wbits = ^wdata_i[W-1:CTRL_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      buf_q  <= '0;
      act_q  <= '0;
      ovf_q  <= 1'b0;
      cmp_q  <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (wr_cmp) buf_q <= wdata_i;
      if (wr_cmp && !pwm)  act_q <= wdata_i;
      else if (upd_i)      act_q <= buf_q;
      ovf_q <= ovf_ev_i | (ovf_q & ~(wr_flag & wdata_i[0]));
      cmp_q <= cmp_ev_i | (cmp_q & ~(wr_flag & wdata_i[1]));
    end
  end

  always_comb begin
    case (addr_i)
      ADDR_CTRL: rdata_o = {{(W-CTRL_W){1'b0}}, ctrl_q};
      ADDR_CNT:  rdata_o = cnt_i;
      ADDR_CMP:  rdata_o = buf_q;
      default:   rdata_o = {{(W-2){1'b0}}, cmp_q, ovf_q};
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign act_o  = act_q;
  assign ovf_o  = ovf_q;
  assign cmp_o  = cmp_q;
endmodule

// File: rtl/tmr8_core.sv
module tmr8_core
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  mode_e        mode_i,
  input  logic [1:0]   cs_i,
  input  logic [W-1:0] act_i,
  input  logic         cnt_wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cnt_o,
  output logic         dn_o,
  output logic         adv_o,
  output logic         match_o,
  output logic         top_o,
  output logic         ovf_ev_o,
  output logic         cmp_ev_o,
  output logic         upd_o
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};
  localparam logic [W-1:0] BOTV = '0;
  localparam logic [W-1:0] ONEV = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         dn_q, dn_d;
  logic         adv, match, top, bot;

  assign adv   = tick_i && (cs_i != 2'd0) && !cnt_wr_i;
  assign match = (cnt_q == act_i);
  assign top   = (cnt_q == MAXV);
  assign bot   = (cnt_q == BOTV);

  always_comb begin
    cnt_d = cnt_q;
    dn_d  = (mode_i == MODE_PHASE) ? dn_q : 1'b0;
    if (cnt_wr_i) begin
      cnt_d = wdata_i;
    end else if (adv) begin
      case (mode_i)
        MODE_CTC:   cnt_d = match ? BOTV : cnt_q + ONEV;
        MODE_PHASE: begin
          if (!dn_q) begin
            if (top) begin
              cnt_d = cnt_q - ONEV;
              dn_d  = 1'b1;
            end else begin
              cnt_d = cnt_q + ONEV;
            end
          end else begin
            if (bot) begin
              cnt_d = cnt_q + ONEV;
              dn_d  = 1'b0;
            end else begin
              cnt_d = cnt_q - ONEV;
            end
          end
        end
        default:    cnt_d = cnt_q + ONEV;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dn_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dn_q  <= dn_d;
    end
  end

  assign cnt_o    = cnt_q;
  assign dn_o     = dn_q;
  assign adv_o    = adv;
  assign match_o  = match;
  assign top_o    = top;
  assign ovf_ev_o = adv && ((mode_i == MODE_PHASE) ? bot : top);
  assign cmp_ev_o = adv && match;
  assign upd_o    = adv && top && mode_i[1];
endmodule

// File: rtl/tmr8_wave.sv
module tmr8_wave
  import tmr8_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       adv_i,
  input  logic       match_i,
  input  logic       top_i,
  input  logic       dn_i,
  input  mode_e      mode_i,
  input  logic [1:0] om_i,
  input  logic       force_i,
  input  logic [1:0] force_om_i,
  output logic       wave_o
);
  logic wave_q, wave_d;

  always_comb begin
    wave_d = wave_q;
    if (adv_i) begin
      case (mode_i)
        MODE_FAST: begin
          if (top_i)        wave_d = pwm_drive(om_i, 1'b1, wave_q);
          else if (match_i) wave_d = pwm_drive(om_i, 1'b0, wave_q);
        end
        MODE_PHASE: if (match_i) wave_d = pwm_drive(om_i, dn_i, wave_q);
        default:    if (match_i) wave_d = cmp_action(om_i, wave_q);
      endcase
    end
    if (force_i) wave_d = cmp_action(force_om_i, wave_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wave_q <= 1'b0;
    else         wave_q <= wave_d;
  end

  assign wave_o = wave_q;
endmodule

// File: rtl/tmr8_pwm.sv
module tmr8_pwm
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         wr_en_i,
  input  logic [1:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  input  logic         port_i,
  output logic         pin_o,
  output logic         ovf_o,
  output logic         cmp_o
);
  ctrl_t        ctrl;
  logic [W-1:0] act_w, cnt_w;
  logic         cnt_wr, force_w;
  logic [1:0]   force_om;
  logic         dn, adv, match, top, ovf_ev, cmp_ev, upd, wave;
  logic [1:0]   mode_w, cs_w;

  assign mode_w = ctrl.mode;
  assign cs_w   = ctrl.cs;

  tmr8_regs #(.W(W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .cnt_i(cnt_w), .ovf_ev_i(ovf_ev), .cmp_ev_i(cmp_ev),
    .upd_i(upd), .ctrl_o(ctrl), .act_o(act_w), .ovf_o(ovf_o), .cmp_o(cmp_o),
    .cnt_wr_o(cnt_wr), .force_o(force_w), .force_om_o(force_om), .rdata_o(rdata_o)
  );

  tmr8_core #(.W(W)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .mode_i(ctrl.mode),
    .cs_i(ctrl.cs), .act_i(act_w), .cnt_wr_i(cnt_wr), .wdata_i(wdata_i),
    .cnt_o(cnt_w), .dn_o(dn), .adv_o(adv), .match_o(match), .top_o(top),
    .ovf_ev_o(ovf_ev), .cmp_ev_o(cmp_ev), .upd_o(upd)
  );

  tmr8_wave u_wave (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(adv), .match_i(match), .top_i(top),
    .dn_i(dn), .mode_i(ctrl.mode), .om_i(ctrl.om), .force_i(force_w),
    .force_om_i(force_om), .wave_o(wave)
  );

  assign pin_o = (ctrl.om != 2'd0) ? wave : port_i;
endmodule

// File: rtl/tmr8_chk.sv
module tmr8_chk #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         tick_i,
  input logic         wr_en_i,
  input logic [1:0]   addr_i,
  input logic [W-1:0] wdata_i,
  input logic [1:0]   mode,
  input logic [1:0]   cs,
  input logic [W-1:0] cnt,
  input logic [W-1:0] act,
  input logic         ovf,
  input logic         cmp
);
  logic cwr, adv, frc;
  assign cwr = wr_en_i && (addr_i == 2'd1);
  assign adv = tick_i && (cs != 2'd0) && !cwr;
  assign frc = wr_en_i && (addr_i == 2'd0) && wdata_i[7];

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs == 2'd0 && !cwr) |=> $stable(cnt));

  assert_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == 2'd0 && adv && cnt == {W{1'b1}}) |=> (ovf && cnt == '0));

  assert_ctc_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == 2'd1 && adv && cnt == act) |=> (cnt == '0 && cmp));

  assert_bottom_ovf_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == 2'd3 && adv && cnt == '0) |=> ovf);

  assert_buffer_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode[1] && !(adv && cnt == {W{1'b1}})) |=> $stable(act));

  assert_force_noflag_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frc && !adv && !ovf && !cmp) |=> (!ovf && !cmp && $stable(cnt)));
endmodule

bind tmr8_pwm tmr8_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_en_i(wr_en_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .mode(mode_w), .cs(cs_w),
  .cnt(cnt_w), .act(act_w), .ovf(ovf_o), .cmp(cmp_o)
);

// File: tb/tmr8_pwm_bench.sv
module tmr8_pwm_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, wr_en = 1'b0, port = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       pin, ovf, cmp;

  int n_chk = 0, n_fail = 0;
  string ctag = "";

  // reference state
  logic [7:0] m_cnt, m_buf, m_act;
  logic [1:0] m_mode, m_om, m_cs;
  logic       m_dn, m_ovf, m_cmp, m_wave;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr8_pwm u_tmr8_pwm (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .port_i(port), .pin_o(pin),
    .ovf_o(ovf), .cmp_o(cmp)
  );

  function automatic logic [7:0] ctl(input logic f, input logic [1:0] cs,
                                     input logic [1:0] om, input logic [1:0] md);
    return {f, 1'b0, cs, om, md};
  endfunction

  function automatic logic [7:0] mread(input logic [1:0] a);
    case (a)
      2'd0:    return {2'b00, m_cs, m_om, m_mode};
      2'd1:    return m_cnt;
      2'd2:    return m_buf;
      default: return {6'd0, m_cmp, m_ovf};
    endcase
  endfunction

  function automatic logic nonpwm_act(input logic [1:0] om, input logic cur);
    case (om)
      2'd1: return ~cur;
      2'd2: return 1'b0;
      2'd3: return 1'b1;
      default: return cur;
    endcase
  endfunction

  function automatic logic pwm_lvl(input logic [1:0] om, input logic lvl, input logic cur);
    if (om == 2'd2) return lvl;
    if (om == 2'd3) return ~lvl;
    return cur;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp, input string what);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s %s: actual %0h expected %0h", tag, ctag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_buf = 0; m_act = 0; m_mode = 0; m_om = 0; m_cs = 0;
    m_dn = 0; m_ovf = 0; m_cmp = 0; m_wave = 0;
  endtask

  task automatic model_step(input logic w, input logic [1:0] a, input logic [7:0] d, input logic t);
    logic adv, match, top, bot, ev_o, ev_c, upd, wn, dn;
    logic [7:0] cn;
    adv   = t && (m_cs != 0) && !(w && a == 2'd1);
    match = (m_cnt == m_act);
    top   = (m_cnt == 8'hFF);
    bot   = (m_cnt == 8'h00);
    cn = m_cnt; dn = (m_mode == 2'd3) ? m_dn : 1'b0; wn = m_wave;
    if (w && a == 2'd1) cn = d;
    else if (adv) begin
      case (m_mode)
        2'd1: cn = match ? 8'h00 : m_cnt + 1;
        2'd3: begin
          if (!m_dn) begin if (top) begin cn = 8'hFE; dn = 1; end else cn = m_cnt + 1; end
          else begin if (bot) begin cn = 8'h01; dn = 0; end else cn = m_cnt - 1; end
        end
        default: cn = m_cnt + 1;
      endcase
      case (m_mode)
        2'd2: begin
          if (top) wn = pwm_lvl(m_om, 1'b1, m_wave);
          else if (match) wn = pwm_lvl(m_om, 1'b0, m_wave);
        end
        2'd3: if (match) wn = pwm_lvl(m_om, m_dn, m_wave);
        default: if (match) wn = nonpwm_act(m_om, m_wave);
      endcase
    end
    if (w && a == 2'd0 && d[7] && !d[1]) wn = nonpwm_act(d[3:2], m_wave);
    ev_o = adv && ((m_mode == 2'd3) ? bot : top);
    ev_c = adv && match;
    upd  = adv && top && m_mode[1];
    if (w && a == 2'd3) begin
      if (d[0]) m_ovf = 0;
      if (d[1]) m_cmp = 0;
    end
    m_ovf = m_ovf | ev_o;
    m_cmp = m_cmp | ev_c;
    if (w && a == 2'd2) begin
      if (!m_mode[1]) m_act = d;
      else if (upd) m_act = m_buf;
      m_buf = d;
    end else if (upd) m_act = m_buf;
    if (w && a == 2'd0) begin m_mode = d[1:0]; m_om = d[3:2]; m_cs = d[5:4]; end
    m_cnt = cn; m_dn = dn; m_wave = wn;
  endtask

  // one cycle: drive after negedge, compare, advance reference, wait next negedge
  task automatic cyc(input logic w, input logic [1:0] a, input logic [7:0] d, input logic t);
    string pt, ot;
    logic  ep;
    wr_en = w; addr = a; wdata = d; tick = t; port = 1'($urandom);
    #1;
    case (m_mode)
      2'd0: begin pt = "R11"; ot = "R3"; end
      2'd1: begin pt = "R11"; ot = "R4"; end
      2'd2: begin pt = "R5";  ot = "R5"; end
      default: begin pt = "R6"; ot = "R6"; end
    endcase
    if (m_om == 2'd0) pt = "R10";
    ep = (m_om == 2'd0) ? port : m_wave;
    chk(pin == ep, pt, pin, ep, "pin");
    chk(ovf == m_ovf, ot, ovf, m_ovf, "ovf");
    chk(cmp == m_cmp, "R8", cmp, m_cmp, "cmp");
    chk(rdata == mread(a), "R13", rdata, mread(a), "rdata");
    model_step(w, a, d, t);
    @(negedge clk);
  endtask

  task automatic peek(input logic [1:0] a, input logic [7:0] e, input string tag);
    wr_en = 0; tick = 0; addr = a;
    #1;
    chk(rdata == e, tag, rdata, e, "read");
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 1);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 180000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic p;
    void'($urandom(32'd5417));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    ctag = "reset";
    for (int a = 0; a < 4; a++) peek(2'(a), 8'h00, "R1");
    port = 1; #1 chk(pin == 1'b1, "R1", pin, 1, "pin port");
    port = 0; #1 chk(pin == 1'b0, "R10", pin, 0, "pin port");
    @(negedge clk);

    ctag = "clksel0";
    cyc(1, 0, ctl(0, 2'd0, 2'd0, 2'd0), 0);
    cyc(1, 1, 8'h10, 0);
    ticks(5);
    peek(1, 8'h10, "R2");

    ctag = "ctc_miss";
    cyc(1, 0, ctl(0, 2'd1, 2'd0, 2'd1), 0);
    cyc(1, 1, 8'hFE, 0);
    cyc(1, 2, 8'h10, 0);
    cyc(1, 3, 8'h03, 0);
    ticks(2);
    peek(1, 8'h00, "R4");
    peek(3, 8'h01, "R4");
    ticks(16);
    peek(1, 8'h10, "R4");
    peek(3, 8'h01, "R4");
    ticks(1);
    peek(1, 8'h00, "R4");
    peek(3, 8'h03, "R4");

    ctag = "flagclr";
    cyc(1, 3, 8'h01, 0);
    peek(3, 8'h02, "R9");
    cyc(1, 3, 8'h02, 0);
    peek(3, 8'h00, "R9");

    ctag = "force";
    cyc(1, 0, ctl(0, 2'd1, 2'd1, 2'd0), 0);
    p = pin;
    cyc(1, 0, ctl(1, 2'd1, 2'd1, 2'd0), 0);
    chk(pin == ~p, "R12", pin, ~p, "force toggle");
    peek(0, ctl(0, 2'd1, 2'd1, 2'd0), "R12");
    peek(3, 8'h00, "R12");
    peek(1, 8'h00, "R12");
    cyc(1, 0, ctl(0, 2'd1, 2'd2, 2'd2), 0);
    p = pin;
    cyc(1, 0, ctl(1, 2'd1, 2'd2, 2'd2), 0);
    chk(pin == p, "R12", pin, p, "force in pwm");

    ctag = "dbuf";
    cyc(1, 0, ctl(0, 2'd1, 2'd0, 2'd1), 0);
    cyc(1, 2, 8'hF0, 0);
    cyc(1, 0, ctl(0, 2'd1, 2'd2, 2'd2), 0);
    cyc(1, 1, 8'h30, 0);
    cyc(1, 2, 8'h40, 0);
    cyc(1, 3, 8'h03, 0);
    ticks(33);
    peek(3, 8'h00, "R7");
    ticks(175);
    peek(1, 8'h00, "R5");
    peek(3, 8'h03, "R5");
    chk(pin == 1'b1, "R5", pin, 1, "set at bottom");
    cyc(1, 3, 8'h03, 0);
    ticks(8'h41);
    chk(pin == 1'b0, "R7", pin, 0, "clear at new compare");
    peek(3, 8'h02, "R7");

    ctag = "random";
    for (int md = 0; md < 4; md++) begin
      for (int om = 0; om < 4; om++) begin
        cyc(1, 0, ctl(0, 2'd1, 2'(om), 2'(md)), 0);
        for (int i = 0; i < 600; i++) begin
          logic       w, t;
          logic [1:0] a, cs;
          logic [7:0] d;
          w  = ($urandom % 100) < 5;
          a  = 2'($urandom);
          d  = 8'($urandom);
          t  = ($urandom % 100) < 70;
          cs = (($urandom % 8) == 0) ? 2'd0 : 2'($urandom % 3 + 1);
          if (a == 2'd0) d = ctl(d[7], cs, 2'(om), 2'(md));
          if (!w) a = 2'($urandom);
          cyc(w, a, d, t);
        end
      end
    end

    summary();
  end
endmodule